// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Pointer Front End

This block sits between an 8-bit host bus and the register file of a two-channel serial controller. The host has only two byte ports per channel: a control port and a data port. The data port always reaches the transmit buffer on writes and the receive buffer on reads. The control port reaches up to seventeen write registers and sixteen read registers through a pointer that the block keeps for each channel.

To use a register other than register 0, the host writes the register number into register 0 through the control port. It then makes a second control access, which lands on that register. After that access the pointer drops back to 0. A command code in register 0 sets the pointer into the upper half of the space. The block also tracks two mode bits per channel. One bit diverts writes of register 7 to a hidden shadow register at index 16. The other bit makes some read indices return stored write-register contents. The block presents each access to the register file as one strobe with a channel, an index and a source flag. The read data comes straight back from the file.

Top module: `sercom_regptr`

## Requirements
- R1: A control-port access (`cs`=1, `cd_sel`=0) made while the channel's pointer is 0 goes to index 0: a write to write register 0, a read to read register 0.
- R2: A control write to register 0 whose bits 5:3 are not 001 loads that channel's pointer with bits 2:0. The next control access on that channel targets that index.
- R3: A control write to register 0 with bits 5:3 equal to 001 loads the pointer with 8 plus bits 2:0.
- R4: Any control access to a nonzero index returns that channel's pointer to 0.
- R5: A control write to index 7 goes to index 16 instead, but only while bit 0 of that channel's write register 15 was last written as 1. Otherwise it goes to index 7.
- R6: While bit 6 of the channel's index-16 register was last written as 1, some control reads return write-register storage, with `rf_wsrc`=1. The mapping is: read 4 to write 4, read 5 to write 5, read 9 to write 3, read 11 to write 10, and read 14 to index 16. Every other read, and every read with the bit clear, uses the read registers with `rf_wsrc`=0.
- R7: A data-port access (`cd_sel`=1) uses index 8 regardless of the pointer and leaves the pointer unchanged.
- R8: The two channels keep independent pointers and mode bits. `ch_sel` (0 or 1) chooses which channel is used.
- R9: A control write to write register 9 with bits 7:6 equal to 11 clears the pointers of both channels.
- R10: With `cs`=0 the strobes are ignored: there is no register-file strobe and no pointer change. When `wr` and `rd` are both high, only the write takes place.
- R11: Reset clears both pointers and all mode bits, and issues no register-file strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| ch_sel | input | 1 | Channel select (0 or 1) |
| cd_sel | input | 1 | 0 = control port, 1 = data port |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| rf_wr | output | 1 | Register-file write strobe |
| rf_rd | output | 1 | Register-file read strobe |
| rf_ch | output | 1 | Channel of the access |
| rf_idx | output | 5 | Register index, 0 to 16 |
| rf_wsrc | output | 1 | Read returns write-register storage |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data |

## Verification
The bench chases the pointer through point-high selection, including a command byte whose low bits also look like a plain register number. A design that ignored the command field would land on the wrong index. It also checks that the pointer returns to 0 after one access; a design that kept the pointer would send the following read to a stale register. The shadow-register case is checked on one channel with the other channel left in plain mode, which catches a mode bit shared between channels. The bench also covers the data port between the pointer write and the register access, the force-reset code clearing the other channel's pending pointer, and accesses with chip select low or with both strobes high.

// File: rtl/sercom_regptr.sv
module sercom_regptr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       ch_sel,
  input  logic       cd_sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       rf_wr,
  output logic       rf_rd,
  output logic       rf_ch,
  output logic [4:0] rf_idx,
  output logic       rf_wsrc,
  output logic [7:0] rf_wdata,
  input  logic [7:0] rf_rdata
);

  localparam logic [4:0] SHADOW_IDX = 5'd16;

  logic [1:0][3:0] ptr_q;
  logic [1:0]      enh_q;
  logic [1:0]      xrd_q;
  logic [3:0]      cur;
  logic            wr_acc, rd_acc, ctl, force_rst;

  assign wr_acc    = cs & wr;
  assign rd_acc    = cs & rd & ~wr;
  assign ctl       = (wr_acc | rd_acc) & ~cd_sel;
  assign cur       = ptr_q[ch_sel];
  assign force_rst = ctl & wr_acc & (cur == 4'd9) & (din[7:6] == 2'b11);

  assign rf_wr    = wr_acc;
  assign rf_rd    = rd_acc;
  assign rf_ch    = ch_sel;
  assign rf_wdata = din;
  assign dout     = rf_rdata;

  always_comb begin
    rf_idx  = {1'b0, cur};
    rf_wsrc = 1'b0;
    if (cd_sel) begin
      rf_idx = 5'd8;
    end else if (wr) begin
      if (cur == 4'd7 && enh_q[ch_sel]) rf_idx = SHADOW_IDX;
    end else if (xrd_q[ch_sel]) begin
      case (cur)
        4'd4, 4'd5: rf_wsrc = 1'b1;
        4'd9:  begin rf_idx = 5'd3;       rf_wsrc = 1'b1; end
        4'd11: begin rf_idx = 5'd10;      rf_wsrc = 1'b1; end
        4'd14: begin rf_idx = SHADOW_IDX; rf_wsrc = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || force_rst) begin
      ptr_q <= '0;
    end else if (ctl) begin
      if (cur == 4'd0 && wr_acc) ptr_q[ch_sel] <= {din[5:3] == 3'b001, din[2:0]};
      else                       ptr_q[ch_sel] <= 4'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh_q <= '0;
      xrd_q <= '0;
    end else if (ctl && wr_acc) begin
      if (cur == 4'd15) enh_q[ch_sel] <= din[0];
      if (cur == 4'd7 && enh_q[ch_sel]) xrd_q[ch_sel] <= din[6];
    end
  end

  // R3
  point_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && wr_acc && cur == 4'd0 && din[5:3] == 3'b001)
      |=> ptr_q[$past(ch_sel)] == {1'b1, $past(din[2:0])});

  // R4
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && cur != 4'd0) |=> ptr_q[$past(ch_sel)] == 4'd0);

  // R5
  shadow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && rf_idx == SHADOW_IDX) |-> enh_q[rf_ch]);

  // R7
  data_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (wr || rd) && cd_sel) |=> $stable(ptr_q));

  // R9
  force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> ptr_q == '0);

  // R10
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!rf_wr && !rf_rd));

endmodule

// File: tb/sercom_regptr_tb_top.sv
module sercom_regptr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, ch_sel = 0, cd_sel = 0, rd = 0, wr = 0;
  logic [7:0] din = 0, dout, rf_wdata, rf_rdata;
  logic rf_wr, rf_rd, rf_ch, rf_wsrc;
  logic [4:0] rf_idx;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed {
    logic w; logic ch; logic [4:0] idx; logic ws; logic [7:0] d;
  } ev_t;
  ev_t   exp_q[$];
  string tag_q[$];
  logic [7:0] wmem [2][17];

  always #4 clk = ~clk;

  sercom_regptr dut_i (.*);

  function automatic logic [7:0] rval(input logic c, input logic [4:0] i);
    return 8'h40 + (c ? 8'h20 : 8'h00) + {3'b0, i};
  endfunction

  assign rf_rdata = rf_wsrc ? wmem[rf_ch][rf_idx] : rval(rf_ch, rf_idx);

  always @(posedge clk) if (rf_wr) wmem[rf_ch][rf_idx] <= rf_wdata;

  always @(negedge clk) begin
    if (rst_n && !done && (rf_wr || rf_rd)) begin
      ev_t a;
      a = '{rf_wr, rf_ch, rf_idx, rf_wsrc, rf_wr ? rf_wdata : dout};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected strobe: actual %h expected none", a);
      end else begin
        ev_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          bad++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic expect_ev(input string t, input logic w, input logic c,
                           input logic [4:0] i, input logic ws, input logic [7:0] d);
    exp_q.push_back('{w, c, i, ws, d});
    tag_q.push_back(t);
  endtask

  task automatic bus(input logic cs_v, input logic c, input logic dsel,
                     input logic w, input logic r, input logic [7:0] d);
    @(posedge clk); #1;
    cs = cs_v; ch_sel = c; cd_sel = dsel; wr = w; rd = r; din = d;
    @(posedge clk); #1;
    cs = 0; wr = 0; rd = 0;
  endtask

  task automatic cwr(input string t, input logic c, input logic [4:0] i, input logic [7:0] d);
    expect_ev(t, 1, c, i, 0, d);
    bus(1, c, 0, 1, 0, d);
  endtask

  task automatic crd(input string t, input logic c, input logic [4:0] i, input logic ws, input logic [7:0] d);
    expect_ev(t, 0, c, i, ws, d);
    bus(1, c, 0, 0, 1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int i = 0; i < 17; i++) wmem[c][i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    total++;
    if (rf_wr !== 0 || rf_rd !== 0) begin
      bad++; $display("FAIL R11: actual %b%b expected 00", rf_wr, rf_rd);
    end
    crd("R11 R1 read reg0", 0, 0, 0, 8'h40);
    cwr("R2 cmd write", 0, 0, 8'h04);
    cwr("R2 target write", 0, 4, 8'hAA);
    crd("R4 back to 0", 0, 0, 0, 8'h40);
    cwr("R3 point high", 0, 0, 8'h0B);
    crd("R3 reg11", 0, 11, 0, 8'h4B);
    crd("R4 after high", 0, 0, 0, 8'h40);
    cwr("R8 ptr ch0", 0, 0, 8'h03);
    cwr("R8 ptr ch1", 1, 0, 8'h05);
    crd("R8 ch1 reg5", 1, 5, 0, 8'h65);
    crd("R8 ch0 reg3", 0, 3, 0, 8'h43);
    cwr("R7 ptr", 0, 0, 8'h02);
    expect_ev("R7 data wr", 1, 0, 8, 0, 8'h55);
    bus(1, 0, 1, 1, 0, 8'h55);
    expect_ev("R7 data rd", 0, 0, 8, 0, 8'h48);
    bus(1, 0, 1, 0, 1, 8'h00);
    crd("R7 ptr kept", 0, 2, 0, 8'h42);
    cwr("R10 ptr", 0, 0, 8'h06);
    bus(0, 0, 0, 1, 0, 8'h77);
    bus(0, 0, 0, 0, 1, 8'h00);
    crd("R10 ptr unchanged", 0, 6, 0, 8'h46);
    expect_ev("R10 wr wins", 1, 0, 0, 0, 8'h00);
    bus(1, 0, 0, 1, 1, 8'h00);
    cwr("R5 ptr7", 0, 0, 8'h07);
    cwr("R5 plain reg7", 0, 7, 8'h11);
    cwr("R5 ptr15", 0, 0, 8'h0F);
    cwr("R5 set enh", 0, 15, 8'h01);
    cwr("R5 ptr7 again", 0, 0, 8'h07);
    cwr("R5 shadow", 0, 16, 8'h40);
    cwr("R5 ch1 ptr7", 1, 0, 8'h07);
    cwr("R5 R8 ch1 plain", 1, 7, 8'h22);
    cwr("R6 ptr3", 0, 0, 8'h03);
    cwr("R6 wr3", 0, 3, 8'hC1);
    cwr("R6 ptr10", 0, 0, 8'h0A);
    cwr("R6 wr10", 0, 10, 8'h5A);
    cwr("R6 ptr4", 0, 0, 8'h04);
    crd("R6 rd4", 0, 4, 1, 8'hAA);
    cwr("R6 ptr9", 0, 0, 8'h09);
    crd("R6 rd9", 0, 3, 1, 8'hC1);
    cwr("R6 ptr11", 0, 0, 8'h0B);
    crd("R6 rd11", 0, 10, 1, 8'h5A);
    cwr("R6 ptr14", 0, 0, 8'h0E);
    crd("R6 rd14", 0, 16, 1, 8'h40);
    cwr("R6 ptr6", 0, 0, 8'h06);
    crd("R6 rd6 status", 0, 6, 0, 8'h46);
    cwr("R6 ch1 ptr4", 1, 0, 8'h04);
    crd("R6 R8 ch1 status", 1, 4, 0, 8'h64);
    cwr("R9 ch1 ptr", 1, 0, 8'h03);
    cwr("R9 ch0 ptr9", 0, 0, 8'h09);
    cwr("R9 force", 0, 9, 8'hC0);
    crd("R9 ch1 cleared", 1, 0, 0, 8'h60);
    crd("R9 ch0 cleared", 0, 0, 0, 8'h40);
    repeat (2) @(posedge clk);
    done = 1;
    total++;
    if (exp_q.size() != 0) begin
      bad++; $display("FAIL R10 missing strobes: actual %0d left expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule